// File: doc/BRIEF.md
# PWM Compare Timer

This block produces a pulse-width-modulated waveform on one output pin from a 16-bit up-counter and two compare values. One compare value marks where the pulse ends. The other marks the end of the period. When the counter meets the period value, three things happen: the counter jumps back to a fixed preset of FFFFh minus 3, the pin takes a programmed "period" level, and a sticky event flag is raised. When the counter meets the pulse value, the pin takes a programmed "pulse" level and the counter keeps counting.

Software programs the block through a small write port. It sets the two compare values and one control word that holds the run bit, the two pin levels and a prescaler select. A clock-enable tick from outside paces the counter, and the prescaler divides that tick by a power of two. Compare writes land in shadow registers. They reach the comparators only at a period reload, so a change in the middle of a period cannot cut a pulse short. With the preset at FFFCh and a period value P, one period lasts P + 5 counter steps.

Top module: `pwm_cmp_timer`

## Requirements
- R1: After reset the pin is 1, the flag is 0, the counter holds FFFCh and the run bit is 0. The control word resets to run=0, pulse level=0, period level=1 and select=0, and both compare values (shadow and active) reset to 0.
- R2: A counter step happens on a cycle with tick high and run set, when the prescaler count masked to its low `sel` bits is all ones. The prescaler clears on each step and counts ticks otherwise, so `sel` gives one step per 2^sel ticks. A step with no period match adds one to the counter, wrapping modulo 2^16.
- R3: On a step where the counter equals the active period value, the counter loads FFFCh and the pin takes the period level.
- R4: On a step where the counter equals the active pulse value and not the period value, the pin takes the pulse level.
- R5: A period match sets the flag. The flag then stays 1 until a cycle with flag_clr_i high. If a set and a clear fall in the same cycle, the flag stays 1.
- R6: When both compare values match on the same step, only the period action takes place: reload, period level on the pin, and the flag.
- R7: Compare writes go to shadow registers. Both active values copy their shadows only on a period match step. A write made in the same cycle as that step takes effect at the following reload.
- R8: While the run bit is 0, the counter and pin hold and the prescaler is cleared. The flag can still be cleared.
- R9: A write at address 0 sets the pulse shadow and address 1 sets the period shadow. Address 2 sets the control word: bit 0 run, bit 1 pulse level, bit 2 period level, bits 5:3 select. A write at address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Clock-enable tick that paces the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 16 | Register write data |
| flag_clr_i | input | 1 | Clears the period event flag |
| pwm_o | output | 1 | PWM output pin |
| flag_o | output | 1 | Sticky period event flag |

## Verification
Two pairs of events can land in the same cycle. The first pair is a pulse match and a period match on the same step. The bench provokes it by leaving both compare values equal, which is also the reset state: the pin must keep the period level, and the counter must reload. The second pair is a flag set and a flag clear. The bench holds flag_clr_i high across several reloads and also asserts it at random, and the flag must read 1 right after every reload step. A bench model steps in lockstep with the design and judges each of these cycles. The same model covers a shadow write made on the reload cycle itself.

// File: rtl/pwm_cmp_timer.sv
module pwm_cmp_timer #(
  parameter int CNT_W      = 16,
  parameter int SEL_W      = 3,
  parameter int RELOAD_VAL = 'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             flag_clr_i,
  output logic             pwm_o,
  output logic             flag_o
);

  localparam int PSC_W = (1 << SEL_W) - 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(RELOAD_VAL);

  logic [CNT_W-1:0] cnt, sh_pulse, sh_period, act_pulse, act_period;
  logic [PSC_W-1:0] psc, psc_mask;
  logic [SEL_W-1:0] sel;
  logic             run, lvl_pulse, lvl_period;
  logic             step, hit_pulse, hit_period, reload;
  logic             wr_pulse, wr_period, wr_ctrl;

  assign psc_mask   = PSC_W'((32'd1 << sel) - 32'd1);
  assign step       = tick_i && run && ((psc & psc_mask) == psc_mask);
  assign hit_period = (cnt == act_period);
  assign hit_pulse  = (cnt == act_pulse);
  assign reload     = step && hit_period;

  assign wr_pulse  = wr_en_i && (wr_addr_i == 2'd0);
  assign wr_period = wr_en_i && (wr_addr_i == 2'd1);
  assign wr_ctrl   = wr_en_i && (wr_addr_i == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_pulse   <= '0;
      sh_period  <= '0;
      run        <= 1'b0;
      lvl_pulse  <= 1'b0;
      lvl_period <= 1'b1;
      sel        <= '0;
    end else begin
      if (wr_pulse)  sh_pulse  <= wr_data_i;
      if (wr_period) sh_period <= wr_data_i;
      if (wr_ctrl) begin
        run        <= wr_data_i[0];
        lvl_pulse  <= wr_data_i[1];
        lvl_period <= wr_data_i[2];
        sel        <= wr_data_i[3 +: SEL_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              psc <= '0;
    else if (!run || step)   psc <= '0;
    else if (tick_i)         psc <= psc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= RELOAD;
      act_pulse  <= '0;
      act_period <= '0;
      pwm_o      <= 1'b1;
    end else if (reload) begin
      cnt        <= RELOAD;
      act_pulse  <= sh_pulse;
      act_period <= sh_period;
      pwm_o      <= lvl_period;
    end else if (step) begin
      cnt <= cnt + 1'b1;
      if (hit_pulse) pwm_o <= lvl_pulse;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_o <= 1'b0;
    else if (reload)     flag_o <= 1'b1;
    else if (flag_clr_i) flag_o <= 1'b0;
  end

  AST_RELOAD_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cnt == RELOAD); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step && !hit_period |=> cnt == $past(cnt) + 16'd1); // R2
  AST_PULSE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    step && hit_pulse && !hit_period |=> pwm_o == $past(lvl_pulse)); // R4
  AST_PERIOD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> pwm_o == $past(lvl_period)); // R6
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> flag_o); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !flag_clr_i |=> flag_o); // R5
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> $stable(act_period) && $stable(act_pulse)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt) && $stable(pwm_o)); // R8

endmodule

// File: tb/pwm_cmp_timer_tb.sv
module pwm_cmp_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, wr_en_i = 1'b0, flag_clr_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        pwm_o, flag_o;

  int errors = 0, checks = 0;
  string tag = "R1";

  logic [15:0] m_cnt, m_sa, m_sb, m_aa, m_ab;
  logic [6:0]  m_psc;
  logic [2:0]  m_sel;
  logic        m_pin, m_flag, m_run, m_lp, m_lr;

  always #4 clk = ~clk;

  pwm_cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .flag_clr_i(flag_clr_i),
    .pwm_o(pwm_o), .flag_o(flag_o)
  );

  function automatic logic [6:0] mask_of(input logic [2:0] s);
    return 7'((32'd1 << s) - 32'd1);
  endfunction

  function automatic logic is_step(input logic t, input logic r,
                                   input logic [6:0] p, input logic [2:0] s);
    return t && r && ((p & mask_of(s)) == mask_of(s));
  endfunction

  task automatic check(input string name, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, name, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 16'hFFFC; m_sa = '0; m_sb = '0; m_aa = '0; m_ab = '0;
    m_psc = '0; m_sel = '0; m_pin = 1'b1; m_flag = 1'b0;
    m_run = 1'b0; m_lp = 1'b0; m_lr = 1'b1;
  endtask

  task automatic cycle(input logic t, input logic we, input logic [1:0] a,
                       input logic [15:0] d, input logic clr);
    logic st, hit;
    tick_i = t; wr_en_i = we; wr_addr_i = a; wr_data_i = d; flag_clr_i = clr;
    st  = is_step(t, m_run, m_psc, m_sel);
    hit = st && (m_cnt == m_ab);
    if (!m_run || st) m_psc = '0; else if (t) m_psc = m_psc + 7'd1;
    if (hit) begin
      m_cnt = 16'hFFFC; m_aa = m_sa; m_ab = m_sb; m_pin = m_lr;
    end else if (st) begin
      if (m_cnt == m_aa) m_pin = m_lp;
      m_cnt = m_cnt + 16'd1;
    end
    if (hit) m_flag = 1'b1; else if (clr) m_flag = 1'b0;
    if (we && a == 2'd0) m_sa = d;
    if (we && a == 2'd1) m_sb = d;
    if (we && a == 2'd2) begin
      m_run = d[0]; m_lp = d[1]; m_lr = d[2]; m_sel = d[5:3];
    end
    @(negedge clk);
    check("pwm_o", pwm_o, m_pin);
    check("flag_o", flag_o, m_flag);
  endtask

  task automatic idle(input int n, input logic t, input logic clr);
    for (int i = 0; i < n; i++) cycle(t, 1'b0, 2'd0, 16'd0, clr);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cycle(1'b1, 1'b1, a, d, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd7321);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    check("pwm_o", pwm_o, 1'b1);
    check("flag_o", flag_o, 1'b0);
    idle(4, 1'b1, 1'b0);

    tag = "R6";                       // both compares 0: period action wins
    wr(2'd2, 16'h0005);               // run, pulse lvl 0, period lvl 1
    idle(4, 1'b1, 1'b0);
    check("flag before 5th step", flag_o, 1'b0);
    idle(1, 1'b1, 1'b0);
    check("flag at reload", flag_o, 1'b1);
    check("pin kept period level", pwm_o, 1'b1);

    tag = "R7";                       // shadows wait for next reload
    wr(2'd0, 16'd3);
    wr(2'd1, 16'd10);
    idle(12, 1'b1, 1'b0);

    tag = "R4";
    idle(40, 1'b1, 1'b0);

    tag = "R5";                       // clear held across reloads: set wins
    idle(45, 1'b1, 1'b1);
    idle(3, 1'b0, 1'b1);

    tag = "R2";                       // half-rate steps, sparse ticks
    wr(2'd2, 16'h000D);
    for (int i = 0; i < 80; i++) cycle(i[1], 1'b0, 2'd0, 16'd0, 1'b0);

    tag = "R8";
    wr(2'd2, 16'h0004);
    idle(30, 1'b1, 1'b0);
    idle(2, 1'b1, 1'b1);

    tag = "R9";                       // address 3 ignored, then levels swapped
    wr(2'd3, 16'hFFFF);
    idle(5, 1'b1, 1'b0);
    wr(2'd2, 16'h0003);
    idle(40, 1'b1, 1'b0);

    tag = "R3";                       // write landing on reload cycle
    for (int i = 0; i < 60; i++)
      cycle(1'b1, 1'b1, 2'd1, 16'(8 + (i % 5)), 1'b0);

    tag = "R2,R3,R4,R5,R7";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      logic [1:0]  a;
      logic [15:0] d;
      r = $urandom;
      a = r[9:8];
      d = (a == 2'd2) ? 16'({r[15:14] % 3, r[13:11], 1'b1 | (r[10] & r[16])})
                      : 16'(r[31:20] % 41);
      cycle(r[1:0] != 2'd0, r[6:2] == 5'd0, a, d, r[19:17] == 3'd0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule